// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Loader

This block holds the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against: an empty-side offset and a full-side offset. A master reset fills both with one of eight built-in values and also fixes, for the rest of operation, which path may later overwrite them. One path is serial, one bit per enabled cycle. The other is parallel, one offset per enabled write-bus cycle. Whichever path is chosen, the stored offsets can be read back one at a time on the read data bus.

A single load-select input steals FIFO cycles. While it is high, an enabled write or read cycle goes to the offset registers instead of the memory. While it is low, this block ignores those cycles. Serial, write-side and read-side activity all arrive as enables qualified on one clock. The block never stalls: it accepts every enabled cycle, so there is no back-pressure. A readback returns its word one cycle after the request, marked by a valid strobe. The consumer has to take that word in the cycle it appears. A partial reset rewinds every access sequence and keeps the stored values and the chosen path.

Top module: `ofs_loader`

## Requirements
- R1: On a clock edge with `mrst` high, both offsets take the default for code c = {`ld`, `fsel[1]`, `fsel[0]`} (`ld` is the MSB). The default is 2^(c+2)−1, saturated to all ones when c+2 ≥ OFS_W.
- R2: On a master-reset edge, `ser_sel` high selects the serial load path and low selects the parallel path; the choice holds until the next master reset.
- R3: In serial mode, each edge with `ser_en` and `ld` high writes `ser_in` into one offset bit. The first OFS_W bits go to the empty offset, LSB first, and the next OFS_W bits go to the full offset, LSB first. After 2·OFS_W bits the sequence wraps to bit 0 of the empty offset.
- R4: In parallel mode, each edge with `wr_en` and `ld` high stores `wr_data[OFS_W-1:0]`. The stores alternate: empty offset first, then full offset, then empty again.
- R5: Load attempts on the path that was not selected leave both offsets unchanged.
- R6: An edge with `rd_en` and `ld` high makes `rd_valid` high in the next cycle. `rd_data` then carries the zero-extended offset, alternating empty first, then full. Without such a request, `rd_valid` is low in the next cycle.
- R7: Readback works the same way in serial mode and in parallel mode.
- R8: A `prst` edge keeps both offsets and the load path. It rewinds the serial bit position, the parallel store sequence and the readback sequence to the empty offset, and it clears `rd_valid`.
- R9: With `ld` low, `ser_en`, `wr_en` and `rd_en` have no effect on the offsets or on the access sequences.
- R10: A master reset rewinds the serial, parallel-store and readback sequences to the empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all accesses |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| ld | input | 1 | Load select; also the MSB of the default code during master reset |
| fsel | input | 2 | Default code bits during master reset |
| ser_sel | input | 1 | Load path chosen at master reset: 1 serial, 0 parallel |
| ser_en | input | 1 | Serial bit enable |
| ser_in | input | 1 | Serial data bit |
| wr_en | input | 1 | Write-side enable |
| wr_data | input | DATA_W | Write data bus |
| rd_en | input | 1 | Read-side enable |
| rd_data | output | DATA_W | Readback word |
| rd_valid | output | 1 | Readback word present this cycle |
| empty_ofs | output | OFS_W | Almost-empty threshold offset |
| full_ofs | output | OFS_W | Almost-full threshold offset |

## Verification
The bench builds the block with OFS_W = 6 and DATA_W = 8. With these values, a full serial load is only twelve bits, so random runs wrap the bit sequence many times. Default codes 4 to 7 hit the saturation rule, while codes 0 to 3 give distinct unsaturated values. The wider data bus carries junk in its upper bits, which lets the bench check that parallel stores truncate them and that readback zero-fills them.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;
endpackage

// File: rtl/ofs_serial_ctl.sv
module ofs_serial_ctl
  import ofs_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rewind,
  input  logic             shift,
  output logic             bit_we,
  output ofs_sel_e         bit_sel,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int NBITS = 2 * OFS_W;
  localparam int CNT_W = $clog2(NBITS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rewind)     cnt <= '0;
    else if (shift) cnt <= (cnt == CNT_W'(NBITS - 1)) ? '0 : cnt + CNT_W'(1);
  end

  always_comb begin
    bit_we  = shift;
    bit_sel = (cnt >= CNT_W'(OFS_W)) ? SEL_FULL : SEL_EMPTY;
    bit_idx = (bit_sel == SEL_FULL) ? IDX_W'(cnt - CNT_W'(OFS_W)) : IDX_W'(cnt);
  end

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rewind)
    shift |=> (cnt < CNT_W'(NBITS)));
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rewind)
    !shift |=> $stable(cnt));
endmodule

// File: rtl/ofs_par_ctl.sv
module ofs_par_ctl
  import ofs_pkg::*;
(
  input  logic     clk,
  input  logic     rewind,
  input  logic     store,
  output logic     word_we,
  output ofs_sel_e word_sel
);
  ofs_sel_e sel_q;

  always_ff @(posedge clk) begin
    if (rewind)     sel_q <= SEL_EMPTY;
    else if (store) sel_q <= (sel_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  end

  assign word_we  = store;
  assign word_sel = sel_q;

  p_wptr_flip_r4: assert property (@(posedge clk) disable iff (rewind)
    store |=> (sel_q != $past(sel_q)));
  p_wptr_hold_r9: assert property (@(posedge clk) disable iff (rewind)
    !store |=> $stable(sel_q));
endmodule

// File: rtl/ofs_regs.sv
module ofs_regs
  import ofs_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic [2:0]       dflt_code,
  input  logic             bit_we,
  input  ofs_sel_e         bit_sel,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  input  logic             word_we,
  input  ofs_sel_e         word_sel,
  input  logic [OFS_W-1:0] word_val,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  logic [OFS_W-1:0] dflt;

  always_comb begin
    if (int'(dflt_code) + 2 >= OFS_W) dflt = '1;
    else dflt = (OFS_W'(1) << (int'(dflt_code) + 2)) - OFS_W'(1);
  end

  logic [OFS_W-1:0] ofs_q [2];

  for (genvar r = 0; r < 2; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (mrst)
        ofs_q[r] <= dflt;
      else if (word_we && (word_sel == ofs_sel_e'(r)))
        ofs_q[r] <= word_val;
      else if (bit_we && (bit_sel == ofs_sel_e'(r)))
        ofs_q[r][bit_idx] <= bit_val;
    end

    p_ofs_hold_r5: assert property (@(posedge clk) disable iff (mrst)
      (!(word_we && word_sel == ofs_sel_e'(r)) && !(bit_we && bit_sel == ofs_sel_e'(r)))
      |=> $stable(ofs_q[r]));
  end

  assign empty_ofs = ofs_q[0];
  assign full_ofs  = ofs_q[1];
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rewind,
  input  logic              rd_req,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  ofs_sel_e rptr;

  always_ff @(posedge clk) begin
    if (rewind) begin
      rptr     <= SEL_EMPTY;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_data <= DATA_W'((rptr == SEL_FULL) ? full_ofs : empty_ofs);
        rptr    <= (rptr == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
      end
    end
  end

  p_rd_valid_r6: assert property (@(posedge clk) disable iff (rewind)
    rd_req |=> rd_valid);
  p_rd_idle_r9: assert property (@(posedge clk) disable iff (rewind)
    !rd_req |=> !rd_valid);
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              ld,
  input  logic [1:0]        fsel,
  input  logic              ser_sel,
  input  logic              ser_en,
  input  logic              ser_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs
);
  localparam int IDX_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;

  logic ser_mode;
  logic active, rewind;
  logic shift, store, rd_req;
  logic bit_we, word_we;
  ofs_sel_e bit_sel, word_sel;
  logic [IDX_W-1:0] bit_idx;
  logic unused_wr_hi;

  assign unused_wr_hi = ^wr_data;
  assign rewind = mrst | prst;
  assign active = ~rewind & ld;
  assign shift  = active & ser_mode & ser_en;
  assign store  = active & ~ser_mode & wr_en;
  assign rd_req = active & rd_en;

  always_ff @(posedge clk) begin
    if (mrst) ser_mode <= ser_sel;
  end

  ofs_serial_ctl #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_ser (
    .clk(clk), .rewind(rewind), .shift(shift),
    .bit_we(bit_we), .bit_sel(bit_sel), .bit_idx(bit_idx)
  );

  ofs_par_ctl u_par (
    .clk(clk), .rewind(rewind), .store(store),
    .word_we(word_we), .word_sel(word_sel)
  );

  ofs_regs #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .mrst(mrst), .dflt_code({ld, fsel}),
    .bit_we(bit_we), .bit_sel(bit_sel), .bit_idx(bit_idx), .bit_val(ser_in),
    .word_we(word_we), .word_sel(word_sel), .word_val(wr_data[OFS_W-1:0]),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  ofs_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rb (
    .clk(clk), .rewind(rewind), .rd_req(rd_req),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  p_mode_keep_r8: assert property (@(posedge clk) disable iff (mrst)
    prst |=> $stable(ser_mode));
  p_exclusive_r5: assert property (@(posedge clk) disable iff (mrst)
    !(bit_we && word_we));
endmodule

// File: tb/ofs_loader_tb.sv
module ofs_loader_tb;
  localparam int W  = 6;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic mrst = 1'b1, prst = 1'b0, ld = 1'b0, ser_sel = 1'b0;
  logic ser_en = 1'b0, ser_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] fsel = 2'b00;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;
  logic [W-1:0] empty_ofs, full_ofs;

  ofs_loader #(.OFS_W(W), .DATA_W(DW)) u_dut (
    .clk(clk), .mrst(mrst), .prst(prst), .ld(ld), .fsel(fsel),
    .ser_sel(ser_sel), .ser_en(ser_en), .ser_in(ser_in),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  int checks = 0, fails = 0;
  logic [W-1:0] m_e, m_f;
  logic m_ser, m_wp, m_rp, m_rv;
  logic [DW-1:0] m_rd;
  int m_sc;

  function automatic logic [W-1:0] dflt_of(input int c);
    if (c + 2 >= W) return '1;
    return W'((1 << (c + 2)) - 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_step();
    if (mrst) begin
      m_e = dflt_of({ld, fsel}); m_f = m_e; m_ser = ser_sel;
      m_wp = 0; m_rp = 0; m_sc = 0; m_rv = 0; m_rd = '0;
    end else if (prst) begin
      m_wp = 0; m_rp = 0; m_sc = 0; m_rv = 0; m_rd = '0;
    end else begin
      m_rv = rd_en & ld;
      if (m_rv) begin
        m_rd = DW'(m_rp ? m_f : m_e);
        m_rp = ~m_rp;
      end
      if (m_ser && ser_en && ld) begin
        if (m_sc < W) m_e[m_sc] = ser_in; else m_f[m_sc - W] = ser_in;
        m_sc = (m_sc == 2 * W - 1) ? 0 : m_sc + 1;
      end
      if (!m_ser && wr_en && ld) begin
        if (m_wp) m_f = wr_data[W-1:0]; else m_e = wr_data[W-1:0];
        m_wp = ~m_wp;
      end
    end
  endfunction

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    mrst = 0; prst = 0; ld = 0; ser_en = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic do_mrst(input logic s, input int code);
    idle(); mrst = 1; ser_sel = s; ld = code[2]; fsel = code[1:0];
    step(); idle();
  endtask

  task automatic par_write(input logic [DW-1:0] d);
    idle(); ld = 1; wr_en = 1; wr_data = d; step(); idle();
  endtask

  task automatic check_all(input string tag);
    chk({tag, " empty"}, 32'(empty_ofs), 32'(m_e));
    chk({tag, " full"},  32'(full_ofs),  32'(m_f));
    chk({tag, " valid"}, 32'(rd_valid),  32'(m_rv));
    if (m_rv) chk({tag, " data"}, 32'(rd_data), 32'(m_rd));
  endtask

  task automatic rand_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      mrst = 0;
      prst = ($urandom % 50) == 0;
      ld = ($urandom % 4) != 0;
      ser_en = $urandom % 2; ser_in = $urandom % 2;
      wr_en = $urandom % 2; wr_data = DW'($urandom);
      rd_en = $urandom % 2;
      step();
      check_all(tag);
    end
    idle();
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      do_mrst(c[0], c);
      chk("R1 empty default", 32'(empty_ofs), 32'(dflt_of(c)));
      chk("R1 full default",  32'(full_ofs),  32'(dflt_of(c)));
      chk("R1 valid cleared", 32'(rd_valid), 0);
    end

    do_mrst(1'b1, 0);
    par_write(8'hAA);
    chk("R5 parallel ignored in serial mode", 32'(empty_ofs), 32'(dflt_of(0)));

    do_mrst(1'b0, 1);
    idle(); ld = 1; ser_en = 1; ser_in = 1; step(); step(); idle();
    chk("R5 serial ignored in parallel mode", 32'(empty_ofs), 32'(dflt_of(1)));
    par_write(8'hC5);
    chk("R2 parallel path selected", 32'(empty_ofs), 32'h05);
    idle(); wr_en = 1; wr_data = 8'h3F; rd_en = 1; step(); idle();
    chk("R9 write without ld", 32'(full_ofs), 32'(dflt_of(1)));
    chk("R9 read without ld", 32'(rd_valid), 0);
    idle(); prst = 1; step(); idle();
    chk("R8 offsets kept", 32'(empty_ofs), 32'h05);
    par_write(8'h11);
    chk("R8 store sequence rewound", 32'(empty_ofs), 32'h11);
    chk("R8 full untouched", 32'(full_ofs), 32'(dflt_of(1)));
    do_mrst(1'b0, 2);
    par_write(8'h01); par_write(8'h02);
    idle(); ld = 1; rd_en = 1; step(); idle();
    chk("R6 first readback empty", 32'(rd_data), 32'h01);
    idle(); ld = 1; rd_en = 1; step(); idle();
    chk("R6 second readback full", 32'(rd_data), 32'h02);
    par_write(8'h07);
    do_mrst(1'b0, 2);
    par_write(8'h09);
    chk("R10 mrst rewinds store sequence", 32'(empty_ofs), 32'h09);

    do_mrst(1'b0, 3);
    rand_run(600, "R4 parallel random");
    do_mrst(1'b1, 6);
    rand_run(600, "R3 R7 serial random");
    do_mrst(1'b1, 5);
    for (int b = 0; b < 2 * W + 1; b++) begin
      idle(); ld = 1; ser_en = 1; ser_in = b[0]; step(); check_all("R3 wrap");
    end
    idle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule